// File: doc/BRIEF.md
# E1 CRC-4 Error Monitor

This block watches the received serial bit stream of an E1 link while a framer reports that CRC-4 multiframe alignment is held. It runs a four-bit cyclic check over each half of the 16-frame multiframe (a sub-multiframe of eight frames). The remainder of one sub-multiframe is then compared with the check bits that arrive inside the sub-multiframe after it. Every mismatch adds one to a local block error counter.

The block also picks out the two far-end error indication bits that each multiframe carries. Each of them that signals an error adds one to a second counter. Both counters wrap to zero when they pass their top value and set a sticky overflow flag. Each flag has its own mask, and the unmasked flags drive one interrupt line. The framer supplies the data bit with a valid qualifier, a strobe on the first bit of every frame and a strobe on the first bit of frame 0 of each multiframe. Alignment search is done by the framer, not here.

Top module: `e1crc_mon`

## Requirements
- R1: After reset both counters read zero, both overflow flags are clear and the interrupt line is low.
- R2: The frame index is set to 0 by a valid bit carrying the multiframe strobe, and it advances by one on each valid bit carrying the frame strobe. The first bit of a frame is the check-bit or far-end-bit position that the other requirements refer to.
- R3: The check is x^4 + x + 1 over the bits of frames 0-7 or 8-15, starting from a zero remainder, with the bits at the check positions taken as zero. The check positions are the first bits of the even-numbered frames. The four received check bits are read most significant first, from frames 0, 2, 4, 6 or from frames 8, 10, 12, 14.
- R4: The check bits of each sub-multiframe are compared with the remainder of the sub-multiframe before it. On the first bit of the following sub-multiframe, a mismatch of any number of bits adds exactly one to the block error counter.
- R5: After alignment is gained, the check bits of the first sub-multiframe begun under alignment are not compared, because no full earlier remainder exists.
- R6: A valid bit received while alignment is low changes neither counter and discards all stored check history, so R5 applies again once alignment returns.
- R7: The first bits of frames 13 and 15 are far-end error bits. Each one received as 0 under alignment adds one to the far-end counter.
- R8: A bit whose valid qualifier is low is ignored: its data, frame strobe and multiframe strobe change no state.
- R9: A counter at its all-ones value that is incremented wraps to zero and sets its overflow flag.
- R10: An overflow flag stays set until its clear strobe is high. A new overflow in the cycle of a clear leaves the flag set.
- R11: The interrupt line is high whenever a set overflow flag has its mask input at 0. A mask input at 1 keeps that flag off the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | CRC-4 multiframe alignment held |
| bit_vld_i | input | 1 | Data bit and strobes are valid this cycle |
| bit_i | input | 1 | Received data bit |
| frm_start_i | input | 1 | First bit of a frame |
| mf_start_i | input | 1 | First bit of frame 0 of a multiframe |
| blk_mask_i | input | 1 | 1 hides the block error overflow from the interrupt |
| far_mask_i | input | 1 | 1 hides the far-end overflow from the interrupt |
| blk_clr_i | input | 1 | Clears the block error overflow flag |
| far_clr_i | input | 1 | Clears the far-end overflow flag |
| blk_cnt_o | output | CNT_W | Block error count |
| far_cnt_o | output | CNT_W | Far-end error count |
| blk_ovf_o | output | 1 | Block error counter overflow flag |
| far_ovf_o | output | 1 | Far-end counter overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the monitor with CNT_W = 3, so both counters wrap after eight events. Overflow, the flags, the clear strobes and the masks are then reached within a few dozen sub-multiframes instead of over a thousand. Because frame length is set only by the strobes, the bench also sends 16-bit frames. This keeps each sub-multiframe at 128 bits, so many random error patterns, alignment drops and idle cycles fit into a short run.

// File: rtl/e1crc_pkg.sv
package e1crc_pkg;
  localparam int MF_FRAMES  = 16;
  localparam int SMF_FRAMES = MF_FRAMES / 2;
  localparam int FIDX_W     = $clog2(MF_FRAMES);
  localparam int SMF_W      = $clog2(SMF_FRAMES);
  localparam int CRC_W      = 4;
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;  // x^4 + x + 1, x^4 implied
  localparam logic [FIDX_W-1:0] FAR1_FRAME = 4'd13;
  localparam logic [FIDX_W-1:0] FAR2_FRAME = 4'd15;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic d);
    logic fb;
    fb = d ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/e1crc_pos.sv
module e1crc_pos
  import e1crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic              frm_start,
  input  logic              mf_start,
  output logic              c_pos,
  output logic              smf_begin,
  output logic              far_pos
);
  logic [FIDX_W-1:0] fcnt_q, fcnt_d, fidx;
  logic              fstart;

  always_comb begin
    fstart = vld & (frm_start | mf_start);
    if (mf_start)       fidx = '0;
    else if (frm_start) fidx = fcnt_q + 1'b1;
    else                fidx = fcnt_q;
    fcnt_d    = vld ? fidx : fcnt_q;
    c_pos     = fstart & ~fidx[0];
    smf_begin = fstart & (fidx[SMF_W-1:0] == '0);
    far_pos   = fstart & ((fidx == FAR1_FRAME) | (fidx == FAR2_FRAME));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcnt_q <= '0;
    else        fcnt_q <= fcnt_d;
  end
endmodule

// File: rtl/e1crc_calc.sv
module e1crc_calc
  import e1crc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic sync,
  input  logic bit_in,
  input  logic c_pos,
  input  logic smf_begin,
  output logic err
);
  logic [CRC_W-1:0] crc_q, crc_d, rx_q, rx_d, ref_q, ref_d;
  logic             have_q, have_d, ref_ok_q, ref_ok_d;
  logic             take, d_eff;

  always_comb begin
    take   = vld & sync;
    d_eff  = bit_in & ~c_pos;
    err    = take & smf_begin & have_q & ref_ok_q & (rx_q != ref_q);
    crc_d    = crc_q;
    rx_d     = rx_q;
    ref_d    = ref_q;
    have_d   = have_q;
    ref_ok_d = ref_ok_q;
    if (vld && !sync) begin
      have_d   = 1'b0;
      ref_ok_d = 1'b0;
    end else if (take) begin
      if (smf_begin) begin
        ref_d    = crc_q;
        ref_ok_d = have_q;
        have_d   = 1'b1;
        crc_d    = crc_step('0, d_eff);
      end else begin
        crc_d    = crc_step(crc_q, d_eff);
      end
      if (c_pos) rx_d = {rx_q[CRC_W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= '0;
      rx_q     <= '0;
      ref_q    <= '0;
      have_q   <= 1'b0;
      ref_ok_q <= 1'b0;
    end else begin
      crc_q    <= crc_d;
      rx_q     <= rx_d;
      ref_q    <= ref_d;
      have_q   <= have_d;
      ref_ok_q <= ref_ok_d;
    end
  end
endmodule

// File: rtl/e1crc_cnt.sv
module e1crc_cnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d, wrap;

  always_comb begin
    wrap  = inc & (cnt_q == {W{1'b1}});
    cnt_d = inc ? cnt_q + 1'b1 : cnt_q;
    ovf_d = wrap | (ovf_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;
endmodule

// File: rtl/e1crc_mon.sv
module e1crc_mon
  import e1crc_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic             frm_start_i,
  input  logic             mf_start_i,
  input  logic             blk_mask_i,
  input  logic             far_mask_i,
  input  logic             blk_clr_i,
  input  logic             far_clr_i,
  output logic [CNT_W-1:0] blk_cnt_o,
  output logic [CNT_W-1:0] far_cnt_o,
  output logic             blk_ovf_o,
  output logic             far_ovf_o,
  output logic             irq_o
);
  localparam int NCNT = 2;

  logic             c_pos, smf_begin, far_pos, blk_err, far_err;
  logic [NCNT-1:0]  inc, clr, ovf, mask;
  logic [CNT_W-1:0] cnt [NCNT];

  e1crc_pos u_pos (
    .clk(clk), .rst_n(rst_n), .vld(bit_vld_i),
    .frm_start(frm_start_i), .mf_start(mf_start_i),
    .c_pos(c_pos), .smf_begin(smf_begin), .far_pos(far_pos)
  );

  e1crc_calc u_calc (
    .clk(clk), .rst_n(rst_n), .vld(bit_vld_i), .sync(sync_i),
    .bit_in(bit_i), .c_pos(c_pos), .smf_begin(smf_begin), .err(blk_err)
  );

  assign far_err = bit_vld_i & sync_i & far_pos & ~bit_i;
  assign inc  = {far_err, blk_err};
  assign clr  = {far_clr_i, blk_clr_i};
  assign mask = {far_mask_i, blk_mask_i};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    e1crc_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc[g]), .clr(clr[g]),
      .cnt(cnt[g]), .ovf(ovf[g])
    );
  end

  assign blk_cnt_o = cnt[0];
  assign far_cnt_o = cnt[1];
  assign blk_ovf_o = ovf[0];
  assign far_ovf_o = ovf[1];
  assign irq_o     = |(ovf & ~mask);
endmodule

// File: rtl/e1crc_mon_chk.sv
module e1crc_mon_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_i,
  input logic             bit_vld_i,
  input logic             blk_mask_i,
  input logic             far_mask_i,
  input logic             blk_clr_i,
  input logic             far_clr_i,
  input logic [CNT_W-1:0] blk_cnt_o,
  input logic [CNT_W-1:0] far_cnt_o,
  input logic             blk_ovf_o,
  input logic             far_ovf_o,
  input logic             irq_o
);
  // R6: no count change after a cycle without alignment
  a_r6_no_count_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> ($stable(blk_cnt_o) && $stable(far_cnt_o)));
  // R8: idle cycles touch no counter
  a_r8_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld_i |=> ($stable(blk_cnt_o) && $stable(far_cnt_o)));
  // R4: block counter moves by at most one
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blk_cnt_o) |-> (blk_cnt_o == $past(blk_cnt_o) + 1'b1));
  // R9: flag rises only on a wrap to zero
  a_r9_blk_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_ovf_o) |-> (blk_cnt_o == '0 && $past(blk_cnt_o) == '1));
  a_r9_far_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(far_ovf_o) |-> (far_cnt_o == '0 && $past(far_cnt_o) == '1));
  // R10: flags are sticky without a clear
  a_r10_blk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_ovf_o && !blk_clr_i) |=> blk_ovf_o);
  a_r10_far_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (far_ovf_o && !far_clr_i) |=> far_ovf_o);
  // R11: masked flags stay off the line
  a_r11_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mask_i && far_mask_i) |-> !irq_o);
  a_r11_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (blk_ovf_o || far_ovf_o));
endmodule

bind e1crc_mon e1crc_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .bit_vld_i(bit_vld_i),
  .blk_mask_i(blk_mask_i), .far_mask_i(far_mask_i),
  .blk_clr_i(blk_clr_i), .far_clr_i(far_clr_i),
  .blk_cnt_o(blk_cnt_o), .far_cnt_o(far_cnt_o),
  .blk_ovf_o(blk_ovf_o), .far_ovf_o(far_ovf_o), .irq_o(irq_o)
);

// File: tb/sim_e1crc_mon.sv
module sim_e1crc_mon;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 3;
  localparam int FB         = 16;
  localparam int SMF_BITS   = 8 * FB;
  localparam int CMOD       = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n, sync_i, bit_vld_i, bit_i, frm_start_i, mf_start_i;
  logic blk_mask_i, far_mask_i, blk_clr_i, far_clr_i;
  logic [CNT_W-1:0] blk_cnt_o, far_cnt_o;
  logic blk_ovf_o, far_ovf_o, irq_o;

  int errors = 0, checks = 0;
  int exp_blk = 0, exp_far = 0;
  bit exp_bovf = 0, exp_fovf = 0;
  bit pend = 0;
  int smf_k = 0;
  logic [3:0] prev_crc = 4'h0;
  logic smf [SMF_BITS];

  always #(CLK_PERIOD/2) clk = ~clk;

  e1crc_mon #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .bit_vld_i(bit_vld_i),
    .bit_i(bit_i), .frm_start_i(frm_start_i), .mf_start_i(mf_start_i),
    .blk_mask_i(blk_mask_i), .far_mask_i(far_mask_i),
    .blk_clr_i(blk_clr_i), .far_clr_i(far_clr_i),
    .blk_cnt_o(blk_cnt_o), .far_cnt_o(far_cnt_o),
    .blk_ovf_o(blk_ovf_o), .far_ovf_o(far_ovf_o), .irq_o(irq_o)
  );

  // remainder of M(x)*x^4 divided by x^4+x+1, by long division
  function automatic logic [3:0] ref_crc();
    logic [4:0] r = 5'b0;
    for (int i = 0; i < SMF_BITS + 4; i++) begin
      logic b;
      if (i >= SMF_BITS) b = 1'b0;
      else if ((i % FB) == 0 && ((i / FB) % 2) == 0) b = 1'b0;
      else b = smf[i];
      r = {r[3:0], b};
      if (r[4]) r = r ^ 5'b10011;
    end
    return r[3:0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " blk_cnt"}, blk_cnt_o, exp_blk);
    check({tag, " far_cnt"}, far_cnt_o, exp_far);
    check({tag, " R9/R10 blk_ovf"}, blk_ovf_o, exp_bovf);
    check({tag, " R9/R10 far_ovf"}, far_ovf_o, exp_fovf);
    check({tag, " R11 irq"}, irq_o,
          (exp_bovf & ~blk_mask_i) | (exp_fovf & ~far_mask_i));
  endtask

  task automatic inc_blk();
    exp_blk = (exp_blk + 1) % CMOD;
    if (exp_blk == 0) exp_bovf = 1;
  endtask

  task automatic inc_far();
    exp_far = (exp_far + 1) % CMOD;
    if (exp_far == 0) exp_fovf = 1;
  endtask

  // R8: idle cycle with garbage on data and strobes
  task automatic idle_cycle();
    bit_vld_i   = 1'b0;
    bit_i       = 1'($urandom);
    frm_start_i = 1'($urandom);
    mf_start_i  = 1'($urandom);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send_smf(input bit sy, input bit half, input logic [3:0] corrupt,
                          input bit fe13, input bit fe15, input bit gaps);
    bit fire;
    for (int i = 0; i < SMF_BITS; i++) smf[i] = 1'($urandom);
    for (int j = 0; j < 4; j++) smf[2*j*FB] = prev_crc[3-j] ^ corrupt[3-j];
    if (half) begin
      smf[5*FB] = fe13;
      smf[7*FB] = fe15;
    end
    sync_i = sy;
    for (int i = 0; i < SMF_BITS; i++) begin
      if (gaps && ($urandom % 5) == 0) idle_cycle();
      bit_vld_i   = 1'b1;
      bit_i       = smf[i];
      frm_start_i = ((i % FB) == 0);
      mf_start_i  = (!half && i == 0);
      @(posedge clk); @(negedge clk);
    end
    bit_vld_i = 1'b0; frm_start_i = 1'b0; mf_start_i = 1'b0;
    fire = sy && pend;
    if (fire) inc_blk();
    if (sy && half) begin
      if (!fe13) inc_far();
      if (!fe15) inc_far();
    end
    pend = sy && (smf_k >= 1) && (corrupt != 4'h0);
    smf_k = sy ? smf_k + 1 : 0;
    prev_crc = ref_crc();
  endtask

  task automatic pulse_clr(input bit b, input bit f);
    blk_clr_i = b; far_clr_i = f;
    @(posedge clk); @(negedge clk);
    blk_clr_i = 1'b0; far_clr_i = 1'b0;
    if (b) exp_bovf = 0;
    if (f) exp_fovf = 0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; sync_i = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0;
    frm_start_i = 1'b0; mf_start_i = 1'b0;
    blk_mask_i = 1'b0; far_mask_i = 1'b0; blk_clr_i = 1'b0; far_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // R6: corrupted check bits and far-end errors without alignment
    send_smf(0, 0, 4'hF, 0, 0, 0);
    send_smf(0, 1, 4'h5, 0, 0, 0);
    check_all("R6 unsynced");

    // R5: first sub-multiframe under alignment is not compared
    send_smf(1, 0, 4'hF, 1, 1, 0);
    check_all("R5 first smf");
    send_smf(1, 1, 4'h0, 1, 1, 0);
    check_all("R5 skipped compare");
    // R3/R4: clean then one-bit and all-bit errors
    send_smf(1, 0, 4'h0, 1, 1, 0);
    check_all("R3 clean");
    send_smf(1, 1, 4'h1, 0, 1, 0);
    check_all("R7 frame13 error");
    send_smf(1, 0, 4'hF, 1, 1, 0);
    check_all("R4 one-bit mismatch counted");
    send_smf(1, 1, 4'h0, 1, 0, 0);
    check_all("R4 all-bit mismatch counts one");

    // R2/R8: random traffic with idle gaps and garbage strobes
    for (int n = 0; n < 40; n++) begin
      logic [3:0] c;
      c = (($urandom % 3) == 0) ? 4'(1 + $urandom % 15) : 4'h0;
      if (n == 20) begin blk_mask_i = 1'b1; far_mask_i = 1'($urandom); end
      send_smf(1, n[0], c, 1'($urandom), 1'($urandom), 1);
      check_all("R2 R8 R9 R11 random");
    end

    // R10: clears, one at a time
    pulse_clr(1, 0);
    check_all("R10 blk clear");
    pulse_clr(0, 1);
    check_all("R10 far clear");
    blk_mask_i = 1'b0; far_mask_i = 1'b0;

    // R6: drop alignment, then R5 applies again
    send_smf(0, 0, 4'h3, 0, 0, 0);
    check_all("R6 drop");
    send_smf(1, 1, 4'hA, 0, 0, 0);
    check_all("R5 regained first");
    send_smf(1, 0, 4'h0, 1, 1, 0);
    check_all("R5 regained skip");

    // R9/R11: drive block counter through a wrap with mask open
    for (int n = 0; n < 2 * CMOD + 2; n++) begin
      send_smf(1, n[0], 4'h8, 1, 0, 0);
      check_all("R9 R11 wrap");
    end
    far_mask_i = 1'b1; blk_mask_i = 1'b1;
    @(negedge clk);
    check("R11 all masked irq", irq_o, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule